// File: doc/BRIEF.md
# Rotate-and-Mask Execution Unit

This unit is the rotate slice of the integer pipeline of a 32-bit load/store processor. It runs three operations, and each one rotates a word left and then keeps part of the result under a mask:

- **Immediate rotate-and-keep:** rotates by an amount taken from the instruction, then clears every bit outside the mask.
- **Insert:** rotates by an amount taken from the instruction, then merges the rotated bits into the old destination value. Only the bits inside the mask come from the rotated word.
- **Register rotate-and-keep:** takes the rotate amount from the low five bits of a register operand, then clears every bit outside the mask.

The mask is a contiguous run of ones. A start index and a stop index give its limits, and both indices count from the most significant bit. When the start index lies after the stop index, the run wraps around the word.

Opcode decoding sits upstream. It presents a 2-bit mode, the instruction word and the three operand values, together with a one-cycle strobe. One cycle later the unit returns the result with a valid strobe. When the instruction's record bit is set, it also raises a write enable for a 4-bit condition field that summarises the result.

Top module: `rot_mask_unit`

## Requirements
- R1: Mask bit position p (p = 0 is the most significant bit, bit 31) is set when start <= p <= stop if start <= stop. It is set when p >= start or p <= stop if start > stop.
- R2: The immediate rotate amount is insn[15:11], the mask start is insn[10:6] and the mask stop is insn[5:1].
- R3: mode 2'b00 gives res_out = rotl(src_val, insn[15:11]) AND mask.
- R4: mode 2'b01 gives res_out = (dst_old AND NOT mask) OR (rotl(src_val, insn[15:11]) AND mask).
- R5: mode 2'b10 and mode 2'b11 give res_out = rotl(src_val, amt_reg[4:0]) AND mask. Bits 31:5 of amt_reg have no effect.
- R6: A rotate amount of 0 leaves src_val unchanged before masking, and an amount of 31 moves bit 0 to bit 31.
- R7: start = stop gives a mask with exactly one bit set. start = 0 with stop = 31 gives all ones.
- R8: cr_we is 1 in the out_valid cycle of an operation whose insn[0] was 1. It is 0 when insn[0] was 0, and 0 in any cycle without out_valid.
- R9: cr_val = {negative, positive, zero, so}. Negative is res_out[31]. Positive means res_out is nonzero with bit 31 clear. Zero means res_out == 0. Bit 0 copies so_in from the strobe cycle.
- R10: out_valid is 1 exactly in the cycle after in_valid. res_out and cr_val hold their values in cycles without a strobe.
- R11: While rst_n is low at a clock edge, out_valid, cr_we, res_out and cr_val all become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe, one cycle per operation |
| mode | input | 2 | 00 immediate rotate-and-keep, 01 insert, 10/11 register rotate-and-keep |
| insn | input | 32 | Instruction word holding the rotate amount, mask limits and record bit |
| src_val | input | 32 | Word to rotate |
| dst_old | input | 32 | Previous destination value used by insert |
| amt_reg | input | 32 | Register rotate amount (low 5 bits used) |
| so_in | input | 1 | Summary-overflow bit copied into the condition field |
| res_out | output | 32 | Registered result |
| cr_we | output | 1 | Condition-field write enable |
| cr_val | output | 4 | Condition field {neg, pos, zero, so} |
| out_valid | output | 1 | Result valid, one cycle after in_valid |

## Verification
The mask is exercised by sweeping every one of the 1024 start/stop pairs with random data and rotate amounts. This separates the contiguous case from the wrapped case, and shows whether the start = stop and full-word edges are handled by the right branch.

Random operations across all four mode codes compare keep against insert against register sourcing. A dst_old that differs from src_val exposes a wrong merge direction. Random upper bits in amt_reg expose a rotate amount that is not truncated to five bits.

Directed cases use rotate amounts 0 and 31, zero and negative results, both values of the record bit and idle cycles. Together they tell apart a correct rotate from a shift, and check the sign classification, the write-enable gating and that the outputs hold between strobes.

// File: rtl/rotmask_pkg.sv
// Package: shared mode encoding and condition-field layout for the rotate unit.
// Assumes a 2-bit mode chosen by upstream decode.
package rotmask_pkg;
    typedef enum logic [1:0] {
        RM_KEEP_IMM = 2'b00,
        RM_INSERT   = 2'b01,
        RM_KEEP_REG = 2'b10,
        RM_KEEP_ALT = 2'b11
    } rm_mode_e;

    typedef struct packed {
        logic neg;
        logic pos;
        logic zero;
        logic so;
    } rm_cr_t;
endpackage

// File: rtl/rm_mask_gen.sv
// Module: rm_mask_gen
// Builds a run of ones from start index to stop index, counting from the MSB.
// When start > stop the run wraps through the word ends.
// Assumes W is a power of two and IW = log2(W).
module rm_mask_gen #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [IW-1:0] start_idx,
    input  logic [IW-1:0] stop_idx,
    output logic [W-1:0]  mask
);
    localparam logic [W-1:0] ONES = '1;
    localparam logic [IW-1:0] TOP = IW'(W - 1);

    logic [W-1:0] from_start;
    logic [W-1:0] upto_stop;

    // Combine a right-shifted and a left-shifted field of ones.
    always_comb begin
        from_start = ONES >> start_idx;
        upto_stop  = ONES << (TOP - stop_idx);
        mask = (start_idx <= stop_idx) ? (from_start & upto_stop)
                                       : (from_start | upto_stop);
    end

    // Guard the edge cases of the mask shape.
    always_comb begin
        // R7
        if (start_idx == stop_idx) single_bit_chk: assert ($countones(mask) == 1);
        // R7
        if (start_idx == '0 && stop_idx == TOP) full_word_chk: assert (mask == ONES);
    end
endmodule

// File: rtl/rm_rotator.sv
// Module: rm_rotator
// Logarithmic left rotator, one stage per amount bit, so no shift by W ever occurs.
// Assumes W is a power of two.
module rm_rotator #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [IW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stage [IW+1];

    assign stage[0] = din;

    for (genvar k = 0; k < IW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        // Rotate by 2**k when amount bit k is set.
        assign stage[k+1] = amt[k] ? {stage[k][W-1-STEP:0], stage[k][W-1:W-STEP]}
                                   : stage[k];
    end

    assign dout = stage[IW];

    // Check the identity rotate.
    always_comb begin
        // R6
        if (amt == '0) rot_zero_chk: assert (dout == din);
    end
endmodule

// File: rtl/rm_cr_calc.sv
// Module: rm_cr_calc
// Classifies a result as negative, positive or zero and appends the overflow copy.
// Assumes a two's-complement result.
module rm_cr_calc #(
    parameter int W = 32
) (
    input  logic [W-1:0]           value,
    input  logic                   so,
    output rotmask_pkg::rm_cr_t    cr
);
    logic is_zero;

    // Produce the signed comparison against zero.
    always_comb begin
        is_zero = (value == '0);
        cr.neg  = value[W-1];
        cr.pos  = !value[W-1] && !is_zero;
        cr.zero = is_zero;
        cr.so   = so;
    end
endmodule

// File: rtl/rot_mask_unit.sv
// Module: rot_mask_unit
// Rotate-and-mask execution unit: keep, insert and register-rotate forms,
// with a one-cycle registered result and optional condition-field update.
// Assumes insn fields: amount [15:11], start [10:6], stop [5:1], record [0].
module rot_mask_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [1:0]   mode,
    input  logic [31:0]  insn,
    input  logic [W-1:0] src_val,
    input  logic [W-1:0] dst_old,
    input  logic [W-1:0] amt_reg,
    input  logic         so_in,
    output logic [W-1:0] res_out,
    output logic         cr_we,
    output logic [3:0]   cr_val,
    output logic         out_valid
);
    import rotmask_pkg::*;

    localparam int IW        = $clog2(W);
    localparam int AMT_LSB   = 11;
    localparam int START_LSB = 6;
    localparam int STOP_LSB  = 1;
    localparam int REC_BIT   = 0;

    logic [IW-1:0] imm_amt, start_idx, stop_idx, rot_amt;
    logic [W-1:0]  mask, rotated, result_nxt;
    rm_mode_e      mode_e;
    rm_cr_t        cr_nxt;

    // Pull the instruction fields apart and choose the rotate source.
    always_comb begin
        imm_amt   = insn[AMT_LSB   +: IW];
        start_idx = insn[START_LSB +: IW];
        stop_idx  = insn[STOP_LSB  +: IW];
        mode_e    = rm_mode_e'(mode);
        rot_amt   = mode[1] ? amt_reg[IW-1:0] : imm_amt;
    end

    rm_mask_gen #(.W(W), .IW(IW)) mask_i (
        .start_idx (start_idx),
        .stop_idx  (stop_idx),
        .mask      (mask)
    );

    rm_rotator #(.W(W), .IW(IW)) rot_i (
        .din  (src_val),
        .amt  (rot_amt),
        .dout (rotated)
    );

    // Apply the mask as keep or as merge with the old destination.
    always_comb begin
        if (mode_e == RM_INSERT) result_nxt = (dst_old & ~mask) | (rotated & mask);
        else                     result_nxt = rotated & mask;
    end

    rm_cr_calc #(.W(W)) cr_i (
        .value (result_nxt),
        .so    (so_in),
        .cr    (cr_nxt)
    );

    // Register the result, condition field and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            cr_we     <= 1'b0;
            res_out   <= '0;
            cr_val    <= '0;
        end else begin
            out_valid <= in_valid;
            cr_we     <= in_valid && insn[REC_BIT];
            if (in_valid) begin
                res_out <= result_nxt;
                cr_val  <= cr_nxt;
            end
        end
    end

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R10
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_out) && $stable(cr_val)));
    // R8
    cr_we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> out_valid);
    // R8
    cr_we_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (cr_we == $past(insn[REC_BIT])));
    // R9
    cr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(cr_val[3:1]) == 1));
    // R9
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cr_val[1] == (res_out == '0)));
    // R9
    so_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (cr_val[0] == $past(so_in)));
endmodule

// File: tb/rot_mask_unit_tb_top.sv
module rot_mask_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [31:0] insn = '0;
    logic [31:0] src_val = '0;
    logic [31:0] dst_old = '0;
    logic [31:0] amt_reg = '0;
    logic        so_in = 1'b0;
    logic [31:0] res_out;
    logic        cr_we;
    logic [3:0]  cr_val;
    logic        out_valid;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rot_mask_unit #(.W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .insn(insn),
        .src_val(src_val), .dst_old(dst_old), .amt_reg(amt_reg), .so_in(so_in),
        .res_out(res_out), .cr_we(cr_we), .cr_val(cr_val), .out_valid(out_valid)
    );

    function automatic logic [31:0] ref_mask(input int mb, input int me);
        logic [31:0] m = '0;
        for (int p = 0; p < 32; p++) begin
            if (mb <= me) m[31-p] = (p >= mb) && (p <= me);
            else          m[31-p] = (p >= mb) || (p <= me);
        end
        return m;
    endfunction

    function automatic logic [31:0] ref_rotl(input logic [31:0] x, input int n);
        logic [63:0] d = {x, x};
        d = d >> (32 - n);
        return d[31:0];
    endfunction

    function automatic logic [31:0] ref_result(input logic [1:0] md, input logic [31:0] ins,
            input logic [31:0] s, input logic [31:0] d, input logic [31:0] a);
        int n = (md[1]) ? int'(a[4:0]) : int'(ins[15:11]);
        logic [31:0] m = ref_mask(int'(ins[10:6]), int'(ins[5:1]));
        logic [31:0] r = ref_rotl(s, n);
        if (md == 2'b01) return (d & ~m) | (r & m);
        return r & m;
    endfunction

    function automatic logic [3:0] ref_cr(input logic [31:0] r, input logic so);
        return {r[31], (!r[31] && r != 0), (r == 0), so};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one operation, then check the registered outputs one cycle later.
    task automatic run_op(input string tag, input logic [1:0] md, input int sh, input int mb,
            input int me, input logic rec, input logic [31:0] s, input logic [31:0] d,
            input logic [31:0] a, input logic so);
        logic [31:0] ins;
        logic [31:0] exp_r;
        ins = $urandom;
        ins[15:11] = sh[4:0];
        ins[10:6]  = mb[4:0];
        ins[5:1]   = me[4:0];
        ins[0]     = rec;
        @(negedge clk);
        in_valid = 1'b1; mode = md; insn = ins; src_val = s; dst_old = d;
        amt_reg = a; so_in = so;
        @(negedge clk);
        in_valid = 1'b0;
        exp_r = ref_result(md, ins, s, d, a);
        check(tag, {res_out, 4'h0, cr_val, 4'h0, cr_we, out_valid, 18'h0},
                   {exp_r, 4'h0, ref_cr(exp_r, so), 4'h0, rec, 1'b1, 18'h0});
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < 150000) begin @(posedge clk); wd++; end
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog actual=%0d expected=done", wd);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", {res_out, cr_val, cr_we, out_valid}, '0);
        rst_n = 1'b1;

        // R1 R2 R3: every start/stop pair
        for (int mb = 0; mb < 32; mb++)
            for (int me = 0; me < 32; me++)
                run_op("R1", 2'b00, int'($urandom % 32), mb, me, 1'($urandom),
                       $urandom, $urandom, $urandom, 1'($urandom));

        // R7 single bit and full mask
        run_op("R7", 2'b00, 0, 9, 9, 1'b1, 32'hFFFF_FFFF, 0, 0, 1'b0);
        run_op("R7", 2'b00, 0, 0, 31, 1'b1, 32'hFFFF_FFFF, 0, 0, 1'b0);
        // R6 rotate by 0 and by 31
        run_op("R6", 2'b00, 0, 0, 31, 1'b0, 32'h8765_4321, 0, 0, 1'b0);
        run_op("R6", 2'b00, 31, 0, 31, 1'b1, 32'h0000_0001, 0, 0, 1'b1);
        run_op("R6", 2'b10, 7, 0, 31, 1'b1, 32'h0000_0001, 0, 32'd31, 1'b0);
        // R4 insert with wrap mask
        run_op("R4", 2'b01, 4, 28, 3, 1'b1, 32'h1234_5678, 32'hAAAA_5555, 0, 1'b0);
        // R5 upper amount bits ignored
        run_op("R5", 2'b10, 0, 0, 31, 1'b1, 32'hF000_000F, 0, 32'hFFFF_FFE4, 1'b0);
        run_op("R5", 2'b11, 0, 4, 20, 1'b0, 32'hDEAD_BEEF, 0, 32'h8000_0021, 1'b1);
        // R9 zero and negative results
        run_op("R9", 2'b00, 3, 5, 5, 1'b1, 32'h0, 0, 0, 1'b1);
        run_op("R9", 2'b00, 0, 0, 0, 1'b1, 32'h8000_0000, 0, 0, 1'b0);
        // R8 record bit clear
        run_op("R8", 2'b01, 1, 2, 30, 1'b0, 32'h5, 32'h7, 0, 1'b0);

        // R10 hold: idle cycle keeps value, no valid
        run_op("R10", 2'b00, 8, 0, 31, 1'b1, 32'h0102_0304, 0, 0, 1'b0);
        @(negedge clk);
        check("R10", {res_out, cr_we, out_valid}, {32'h0203_0401, 1'b0, 1'b0});

        // R3 R4 R5 random mix
        for (int i = 0; i < 3000; i++)
            run_op("R3", 2'($urandom), int'($urandom % 32), int'($urandom % 32),
                   int'($urandom % 32), 1'($urandom), $urandom, $urandom, $urandom,
                   1'($urandom));

        // R11 reset mid-stream
        @(negedge clk);
        in_valid = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R11", {res_out, cr_val, cr_we, out_valid}, '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule